// File: doc/BRIEF.md
# Multi-Character Comma Framer

This block sits behind a deserializer whose character clock is already recovered and free-running. Each lane receives one raw 10-bit character per clock. The block keeps the previous and the current character as a 20-bit window. It looks for the comma prefix of the K28.5 framing character at each of the ten possible bit offsets in that window. A new character boundary is adopted only when four framing characters arrive back to back, all at the same offset. The clock is never moved. Instead, the data is shifted through a barrel selector so that it fits the existing character period.

Each lane keeps its own boundary. A single enable input gates boundary changes for all lanes at once. When the enable is low, the block goes on shifting data at the boundary it already holds, whatever framing characters arrive. When a lane adopts a new boundary, it raises a one-cycle realign strobe and marks that cycle's output character as not valid.

Top module: `comma_framer`

## Requirements
- R1: While reset is low, every lane drives an output character of 0, valid low and realign low, and its active offset returns to 0.
- R2: Bit 9 of each input character is the earliest in time. A comma is the 7-bit prefix 0011111 or 1100000 beginning at offset 0 to 9 of the window formed by the previous character followed by the current character.
- R3: Suppose the enable is high and four consecutive input characters each carry a comma starting at the same offset, and that offset differs from the active one. Then the active offset takes that value, and realign is high for exactly one cycle. The strobe appears two clock edges after the capture of the input character that holds the first bit of the fourth comma.
- R4: Each output character is the 10 bits starting at the active offset within the character captured two edges earlier. Once a lane has aligned to a comma stream, it emits the transmitted characters unchanged.
- R5: Outside reset, valid is low exactly in the cycles where that lane's realign is high, and high in all other cycles.
- R6: Commas found at the offset already active are counted, but they never raise realign and never disturb the output stream.
- R7: A character window with no comma ends the current run. Three commas, one non-comma character, then three more commas give no realign. A following run of four realigns at its own fourth comma.
- R8: While the enable is low, no lane raises realign or changes offset, even after four or more matching commas. The old alignment keeps being used after the enable returns high.
- R9: Lanes keep independent offsets under the shared enable. A lane whose comma offset already matches stays silent while another lane realigns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | Shared enable for boundary changes on all lanes |
| rx_char | input | LANES*10 | Raw received characters, lane n in bits [10n+9:10n] |
| al_char | output | LANES*10 | Realigned output characters, same lane packing |
| al_valid | output | LANES | Output character valid, per lane |
| realign | output | LANES | One-cycle pulse when a lane adopts a new offset |

## Verification
A wrong offset register or a wrong barrel slice corrupts every output character from the next cycle on. Comparing each output against the transmitted symbol two characters back therefore exposes the error on the first character after alignment. A wrong run counter shows up as a realign strobe that comes one character early or late, or never arrives. Checking the strobe and valid on every cycle pins that down to the exact edge. Under a low enable, a stray boundary change stays invisible until real traffic flows. For that reason, filler traffic after the enable returns high is checked against the old alignment.

// File: rtl/framer_pkg.sv
// Package: shared constants for the comma framer.
// Assumes 10-bit transmission characters, with bit 9 earliest in time.
package framer_pkg;
    localparam int CHAR_W  = 10;
    localparam int WIN_W   = 2 * CHAR_W;
    localparam int COMMA_W = 7;
    localparam int OFF_W   = $clog2(CHAR_W);

    localparam logic [COMMA_W-1:0] COMMA_POS = 7'b0011111;
    localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b1100000;

    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [WIN_W-1:0]  win_t;
endpackage

// File: rtl/comma_scan.sv
// comma_scan: looks for the comma prefix at each bit offset of a 20-bit window
// and reports the lowest offset that matches.
// Assumes window bit WIN_W-1 is the earliest bit; offset k starts at bit WIN_W-1-k.
module comma_scan
    import framer_pkg::*;
(
    input  win_t win,
    output logic hit,
    output off_t hit_off
);
    logic [CHAR_W-1:0] match;

    // Compare the comma prefix at each candidate offset
    for (genvar k = 0; k < CHAR_W; k++) begin : g_off
        assign match[k] = (win[WIN_W-1-k -: COMMA_W] == COMMA_POS) ||
                          (win[WIN_W-1-k -: COMMA_W] == COMMA_NEG);
    end

    // Priority select: the lowest matching offset wins
    always_comb begin
        hit_off = '0;
        for (int k = CHAR_W - 1; k >= 0; k--) begin
            if (match[k]) hit_off = off_t'(k);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/barrel_sel.sv
// barrel_sel: picks the 10-bit character that starts at a given offset in the window.
// Assumes off < CHAR_W; an out-of-range offset yields zero.
module barrel_sel
    import framer_pkg::*;
(
    input  win_t  win,
    input  off_t  off,
    output char_t ch
);
    char_t cand [CHAR_W];

    // One candidate slice per offset
    for (genvar k = 0; k < CHAR_W; k++) begin : g_slice
        assign cand[k] = win[WIN_W-1-k -: CHAR_W];
    end

    // Multiplexer indexed by the active offset
    always_comb begin
        ch = '0;
        for (int k = 0; k < CHAR_W; k++) begin
            if (off == off_t'(k)) ch = cand[k];
        end
    end
endmodule

// File: rtl/run_tracker.sv
// run_tracker: counts consecutive comma detections at one offset and commits
// a new active offset after RUN_LEN of them, when enabled.
// Assumes exactly one detection decision per character clock.
module run_tracker
    import framer_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    input  off_t hit_off,
    output off_t act_off,
    output logic strobe
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [CNT_W-1:0] cnt_q, cnt_n;
    off_t             run_off_q, run_off_n;
    off_t             act_off_q;
    logic             strobe_q;
    logic             fire;

    // Next run length and run offset
    always_comb begin
        run_off_n = run_off_q;
        if (!hit) begin
            cnt_n = '0;
        end else if (cnt_q != '0 && hit_off == run_off_q) begin
            cnt_n = (cnt_q == CNT_W'(RUN_LEN)) ? cnt_q : cnt_q + 1'b1;
        end else begin
            cnt_n     = CNT_W'(1);
            run_off_n = hit_off;
        end
    end

    // A qualified run at a new offset commits only when enabled
    always_comb begin
        fire = en && hit && (cnt_n == CNT_W'(RUN_LEN)) && (hit_off != act_off_q);
    end

    // Run state, active offset and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            run_off_q <= '0;
            act_off_q <= '0;
            strobe_q  <= 1'b0;
        end else begin
            cnt_q     <= cnt_n;
            run_off_q <= run_off_n;
            strobe_q  <= fire;
            if (fire) act_off_q <= hit_off;
        end
    end

    assign act_off = act_off_q;
    assign strobe  = strobe_q;

    AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> $past(en)); // R8
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_q |-> $stable(act_off_q)); // R3
    AST_STROBE_MOVES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> act_off_q != $past(act_off_q)); // R6
    AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_off_q < off_t'(CHAR_W)); // R2
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && RUN_LEN > 1) |=> !strobe_q); // R3
endmodule

// File: rtl/framer_lane.sv
// framer_lane: one channel of the framer. Holds the two-character window,
// finds commas, tracks runs and emits the realigned, registered character.
// Assumes one raw character per clock from an already recovered character clock.
module framer_lane
    import framer_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  char_t raw,
    output char_t dout,
    output logic  dout_valid,
    output logic  realign
);
    char_t cur_q, prev_q, dout_q, sel_ch;
    logic  valid_q;
    logic  hit;
    off_t  hit_off, act_off;
    win_t  win;

    // Two-character history forming the search window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= raw;
            prev_q <= cur_q;
        end
    end

    assign win = {prev_q, cur_q};

    comma_scan u_scan (
        .win     (win),
        .hit     (hit),
        .hit_off (hit_off)
    );

    run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .hit     (hit),
        .hit_off (hit_off),
        .act_off (act_off),
        .strobe  (realign)
    );

    barrel_sel u_sel (
        .win (win),
        .off (act_off),
        .ch  (sel_ch)
    );

    // Output character register and the post-reset valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            dout_q  <= sel_ch;
            valid_q <= 1'b1;
        end
    end

    assign dout       = dout_q;
    assign dout_valid = valid_q && !realign;

    AST_STROBE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> $past(hit)); // R3
endmodule

// File: rtl/comma_framer.sv
// comma_framer: a multi-lane comma framer with one shared enable for boundary changes.
// Assumes the lanes are packed into flat buses, with lane n at bits [10n+9:10n].
module comma_framer
    import framer_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int RUN_LEN = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_en,
    input  logic [LANES*CHAR_W-1:0] rx_char,
    output logic [LANES*CHAR_W-1:0] al_char,
    output logic [LANES-1:0]        al_valid,
    output logic [LANES-1:0]        realign
);
    // One independent framer per lane under the common enable
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        framer_lane #(.RUN_LEN(RUN_LEN)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (frame_en),
            .raw        (rx_char[n*CHAR_W +: CHAR_W]),
            .dout       (al_char[n*CHAR_W +: CHAR_W]),
            .dout_valid (al_valid[n]),
            .realign    (realign[n])
        );
    end
endmodule

// File: tb/comma_framer_test.sv
`timescale 1ns/1ps
module comma_framer_test;
    import framer_pkg::*;

    localparam int LANES = 2;
    localparam int W     = CHAR_W;

    localparam logic [9:0] SA = 10'b1010101010;
    localparam logic [9:0] SB = 10'b0101010101;
    localparam logic [9:0] SD = 10'b0110011001;
    localparam logic [9:0] CP = 10'b0011111010;
    localparam logic [9:0] CN = 10'b1100000101;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frame_en = 1'b0;
    logic [LANES*W-1:0]   rx_char = '0;
    logic [LANES*W-1:0]   al_char;
    logic [LANES-1:0]     al_valid;
    logic [LANES-1:0]     realign;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [9:0] seq [0:31];
    int seq_len = 0;
    int cur_off [LANES];

    always #10 clk = ~clk;

    comma_framer #(.LANES(LANES), .RUN_LEN(4)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_en (frame_en),
        .rx_char  (rx_char),
        .al_char  (al_char),
        .al_valid (al_valid),
        .realign  (realign)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] chop(input logic [9:0] p, input logic [9:0] c, input int k);
        logic [19:0] w;
        w = {p, c} >> k;
        return w[9:0];
    endfunction

    task automatic set_seq(input logic [9:0] v [], input int n);
        for (int i = 0; i < n; i++) seq[i] = v[i];
        seq_len = n;
    endtask

    // Stream seq with each lane shifted by its offset, and check every cycle
    task automatic run_trial(input int off0, input int off1, input int strobe_at,
                             input int chk_from, input bit enable, input string tag);
        int offs [LANES];
        offs[0] = off0;
        offs[1] = off1;
        for (int i = 0; i < seq_len; i++) begin
            for (int l = 0; l < LANES; l++) begin
                rx_char[l*W +: W] = chop((i == 0) ? SA : seq[i-1], seq[i], offs[l]);
            end
            frame_en = enable;
            @(posedge clk);
            @(negedge clk);
            for (int l = 0; l < LANES; l++) begin
                bit exp_s;
                exp_s = enable && (i == strobe_at) && (offs[l] != cur_off[l]);
                check(realign[l] == exp_s, tag, $sformatf("lane%0d step%0d realign", l, i),
                      int'(realign[l]), int'(exp_s));
                check(al_valid[l] == !exp_s, {tag, "/R5"}, $sformatf("lane%0d step%0d valid", l, i),
                      int'(al_valid[l]), int'(!exp_s));
                if (chk_from >= 0 && i >= chk_from)
                    check(al_char[l*W +: W] == seq[i-2], {tag, "/R4"},
                          $sformatf("lane%0d step%0d char", l, i),
                          int'(al_char[l*W +: W]), int'(seq[i-2]));
            end
        end
        if (enable && strobe_at >= 0)
            for (int l = 0; l < LANES; l++) cur_off[l] = offs[l];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_off[0] = 0;
        cur_off[1] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            check(al_char[l*W +: W] == '0, "R1", "reset char", int'(al_char[l*W +: W]), 0);
            check(al_valid[l] == 1'b0, "R1", "reset valid", int'(al_valid[l]), 0);
            check(realign[l] == 1'b0, "R1", "reset realign", int'(realign[l]), 0);
        end
        rst_n = 1'b1;

        // R2 R3 R4 R9: sweep every offset; lane1 runs five offsets ahead
        for (int o = 0; o <= 10; o++) begin
            set_seq('{SA, SA, SB, CP, CN, CP, CN, SA, SD, SB, SD, SA, SA}, 13);
            run_trial(o % 10, (o + 5) % 10, 8, 9, 1'b1, "R2/R3/R9");
        end

        // R6: commas at the active offset give no strobe
        set_seq('{SA, SA, SB, CP, CN, CP, CN, SA, SD, SB, SD, SA, SA}, 13);
        run_trial(cur_off[0], cur_off[1], 8, 2, 1'b1, "R6");

        // R7: a broken run of three plus three does not realign
        set_seq('{SA, SA, CP, CN, CP, SA, CN, CP, CN, SD, SA, SA}, 12);
        run_trial(3, 7, -1, -1, 1'b1, "R7");
        // R7: a fresh run of four after a break realigns
        set_seq('{SA, SA, CP, CN, CP, SB, CP, CN, CP, CN, SA, SD, SA, SA}, 14);
        run_trial(3, 7, 11, 12, 1'b1, "R7");

        // R8: a disabled framer ignores a qualified run at new offsets
        set_seq('{SA, SA, SB, CP, CN, CP, CN, SA, SD, SB, SD, SA, SA}, 13);
        run_trial(6, 2, 8, -1, 1'b0, "R8");
        // R8: the old alignment is still in use once the enable returns
        set_seq('{SA, SB, SD, SA, SB, SD, SA, SA}, 8);
        run_trial(cur_off[0], cur_off[1], -1, 2, 1'b1, "R8");
        set_seq('{SA, SA, SB, CP, CN, CP, CN, SA, SD, SB, SD, SA, SA}, 13);
        run_trial(6, 2, 8, 9, 1'b1, "R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule